// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Selectable Write Policies

This block is a direct-mapped data cache controller that sits between a CPU load/store port and a lower memory level. Two parameters set how writes behave. The write-hit policy is either write-back or write-through. The write-miss policy is either allocate or no-allocate. Each line holds a tag, a valid bit and a block of words. A dirty bit is kept for each line only when the controller is built in write-back mode.

The CPU side uses a valid/ready request channel and a one-cycle response pulse that carries read data. Writes get no response; they complete when ready comes back. Lower memory is reached through two ports:
- a line port that carries whole-line fills and whole-line write-backs;
- a word write port that stands in for a write buffer. It carries write-through stores and stores that miss without allocating.

Addresses are word addresses. The low bits select the word within a line, the next bits select the line, and the remaining upper bits form the tag.

Top module: `wpcache_ctrl`

## Requirements
- R1: After reset every line is invalid. `cpu_req_ready` is high, `cpu_rsp_valid` is low, and the first access to any address misses.
- R2: A read that hits returns the stored word on `cpu_rsp_data` with `cpu_rsp_valid` high in the cycle after acceptance. It keeps `cpu_req_ready` high and causes no memory transaction.
- R3: A read miss whose victim line is invalid or clean issues exactly one line fill, with line address = word address >> log2(WORDS) and no write-back. `cpu_req_ready` is low from the cycle after acceptance until the response. The response is the requested word, where word w of a line sits at bits [w*DATA_W +: DATA_W].
- R4: In write-back mode a write hit updates only the cached word and marks the line dirty. It causes no memory transaction, and a later read returns the new value.
- R5: In write-back mode a miss that displaces a valid dirty line first writes the whole victim line, including its modified words, to the victim's line address, and only then requests the fill. A write-back is only ever issued for a line that is both valid and dirty.
- R6: With write-allocate, a write miss fetches the line from memory, merges the written word into it, and issues no word write in write-back mode. The other words of the line then hit with their memory values.
- R7: In write-through mode every write hit updates the cached word and sends the same word to the word write port. An evicted line is never written back.
- R8: With write no-allocate, a write miss sends the word to the word write port and leaves the cache unchanged. A later read of that address misses and returns the new value from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| cpu_rsp_data | output | DATA_W | Read data |
| mem_line_req_valid | output | 1 | Line request present |
| mem_line_req_ready | input | 1 | Memory accepts line request |
| mem_line_req_we | output | 1 | 1 = line write-back, 0 = line fill |
| mem_line_req_addr | output | ADDR_W-log2(WORDS) | Line address |
| mem_line_req_wdata | output | WORDS*DATA_W | Line being written back |
| mem_line_rsp_valid | input | 1 | Fill data valid |
| mem_line_rsp_data | input | WORDS*DATA_W | Fill data |
| mem_word_wr_valid | output | 1 | Word write present |
| mem_word_wr_ready | input | 1 | Memory accepts word write |
| mem_word_wr_addr | output | ADDR_W | Word write address |
| mem_word_wr_data | output | DATA_W | Word write data |

## Verification
The bench builds one write-back/allocate controller and one write-through/no-allocate controller, and watches the memory traffic each one produces.

It forces a conflict miss on a line that was dirtied by a write hit. A design that skipped the write-back, or issued it after the fill, would lose the store. The bench catches this because the memory model records how many write-backs had already arrived when the fill was requested.

It checks that a write hit leaves memory untouched in write-back mode and updates it in write-through mode, so a swapped policy is visible. It also checks that misses after reset issue no write-back. A design that trusted the dirty bit without the valid bit would fail that check.

On the no-allocate side it checks that a write miss leaves no line installed, so the following read must fetch the line again. After a write-allocate miss it checks that the neighbouring words come from memory, which exposes a merge that clobbers the wrong word.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_WORD_WR
    } wpc_state_e;

endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
    parameter int LINES      = 16,
    parameter int TAG_W      = 6,
    parameter bit WITH_DIRTY = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic [TAG_W-1:0]         rd_tag,
    output logic                     rd_valid,
    output logic                     rd_dirty,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic                     wr_dirty
);

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];

    generate
        if (WITH_DIRTY) begin : g_dirty
            logic [LINES-1:0] dirty_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dirty_q <= '0;
                end else if (wr_en) begin
                    dirty_q[wr_idx] <= wr_dirty;
                end
            end
            assign rd_dirty = dirty_q[rd_idx];
        end else begin : g_clean
            assign rd_dirty = 1'b0;
        end
    endgenerate

    AST_RESET_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_q == '0)); // R1

endmodule

// File: rtl/wpc_line_store.sv
module wpc_line_store #(
    parameter int LINES  = 16,
    parameter int LINE_W = 128
) (
    input  logic                     clk,
    input  logic [$clog2(LINES)-1:0] rd_idx,
    output logic [LINE_W-1:0]        rd_line,
    input  logic                     wr_en,
    input  logic [$clog2(LINES)-1:0] wr_idx,
    input  logic [LINE_W-1:0]        wr_line
);

    logic [LINE_W-1:0] line_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/wpcache_ctrl.sv
module wpcache_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int WORDS       = 4,
    parameter int LINES       = 16,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cpu_req_valid,
    output logic                                 cpu_req_ready,
    input  logic                                 cpu_req_we,
    input  logic [ADDR_W-1:0]                    cpu_req_addr,
    input  logic [DATA_W-1:0]                    cpu_req_wdata,
    output logic                                 cpu_rsp_valid,
    output logic [DATA_W-1:0]                    cpu_rsp_data,
    output logic                                 mem_line_req_valid,
    input  logic                                 mem_line_req_ready,
    output logic                                 mem_line_req_we,
    output logic [ADDR_W-$clog2(WORDS)-1:0]      mem_line_req_addr,
    output logic [WORDS*DATA_W-1:0]              mem_line_req_wdata,
    input  logic                                 mem_line_rsp_valid,
    input  logic [WORDS*DATA_W-1:0]              mem_line_rsp_data,
    output logic                                 mem_word_wr_valid,
    input  logic                                 mem_word_wr_ready,
    output logic [ADDR_W-1:0]                    mem_word_wr_addr,
    output logic [DATA_W-1:0]                    mem_word_wr_data
);

    localparam int OFF_W   = $clog2(WORDS);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int LINE_W  = WORDS * DATA_W;

    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        wpc_state_e        st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              rsp_valid;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t c_q, c_d;

    function automatic logic [DATA_W-1:0] pick_word(line_t line, logic [OFF_W-1:0] off);
        return line[off*DATA_W +: DATA_W];
    endfunction

    function automatic line_t put_word(line_t line, logic [OFF_W-1:0] off, logic [DATA_W-1:0] w);
        line_t m;
        m = line;
        m[off*DATA_W +: DATA_W] = w;
        return m;
    endfunction

    // lookup port of both stores follows the incoming request while idle
    logic [ADDR_W-1:0] look_addr;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [OFF_W-1:0]  look_off;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid, rd_dirty;
    line_t             rd_line;
    logic              tag_we, wr_dirty;
    logic              data_we;
    line_t             wr_line;
    logic              accept, hit;

    assign look_addr = (c_q.st == ST_IDLE) ? cpu_req_addr : c_q.addr;
    assign look_off  = look_addr[OFF_W-1:0];
    assign look_idx  = look_addr[OFF_W +: IDX_W];
    assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];

    wpc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .WITH_DIRTY(WRITE_BACK)) i_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(look_idx), .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
        .wr_en(tag_we), .wr_idx(look_idx), .wr_tag(look_tag), .wr_dirty(wr_dirty)
    );

    wpc_line_store #(.LINES(LINES), .LINE_W(LINE_W)) i_lines (
        .clk(clk),
        .rd_idx(look_idx), .rd_line(rd_line),
        .wr_en(data_we), .wr_idx(look_idx), .wr_line(wr_line)
    );

    assign accept = (c_q.st == ST_IDLE) && cpu_req_valid;
    assign hit    = rd_valid && (rd_tag == look_tag);

    always_comb begin
        c_d                = c_q;
        c_d.rsp_valid      = 1'b0;
        tag_we             = 1'b0;
        wr_dirty           = 1'b0;
        data_we            = 1'b0;
        wr_line            = rd_line;
        mem_line_req_valid = 1'b0;
        mem_line_req_we    = 1'b0;
        mem_line_req_addr  = look_addr[ADDR_W-1:OFF_W];
        mem_line_req_wdata = rd_line;
        mem_word_wr_valid  = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    c_d.we    = cpu_req_we;
                    c_d.addr  = cpu_req_addr;
                    c_d.wdata = cpu_req_wdata;
                    if (hit && !cpu_req_we) begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rdata     = pick_word(rd_line, look_off);
                    end else if (hit) begin
                        data_we = 1'b1;
                        wr_line = put_word(rd_line, look_off, cpu_req_wdata);
                        if (WRITE_BACK) begin
                            tag_we   = 1'b1;
                            wr_dirty = 1'b1;
                        end else begin
                            c_d.st = ST_WORD_WR;
                        end
                    end else if (cpu_req_we && !WRITE_ALLOC) begin
                        c_d.st = ST_WORD_WR;
                    end else if (rd_valid && rd_dirty) begin
                        c_d.st = ST_EVICT;
                    end else begin
                        c_d.st = ST_FILL_REQ;
                    end
                end
            end
            ST_EVICT: begin
                mem_line_req_valid = 1'b1;
                mem_line_req_we    = 1'b1;
                mem_line_req_addr  = {rd_tag, look_idx};
                if (mem_line_req_ready) c_d.st = ST_FILL_REQ;
            end
            ST_FILL_REQ: begin
                mem_line_req_valid = 1'b1;
                if (mem_line_req_ready) c_d.st = ST_FILL_WAIT;
            end
            ST_FILL_WAIT: begin
                if (mem_line_rsp_valid) begin
                    tag_we   = 1'b1;
                    data_we  = 1'b1;
                    wr_dirty = c_q.we && WRITE_BACK;
                    wr_line  = c_q.we ? put_word(mem_line_rsp_data, look_off, c_q.wdata)
                                      : mem_line_rsp_data;
                    if (!c_q.we) begin
                        c_d.rsp_valid = 1'b1;
                        c_d.rdata     = pick_word(mem_line_rsp_data, look_off);
                        c_d.st        = ST_IDLE;
                    end else begin
                        c_d.st = WRITE_BACK ? ST_IDLE : ST_WORD_WR;
                    end
                end
            end
            ST_WORD_WR: begin
                mem_word_wr_valid = 1'b1;
                if (mem_word_wr_ready) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cpu_req_ready    = (c_q.st == ST_IDLE);
    assign cpu_rsp_valid    = c_q.rsp_valid;
    assign cpu_rsp_data     = c_q.rdata;
    assign mem_word_wr_addr = c_q.addr;
    assign mem_word_wr_data = c_q.wdata;

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && !cpu_req_we) |=> (cpu_rsp_valid && cpu_req_ready)); // R2

    AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit && !(cpu_req_we && (WRITE_ALLOC == 1'b0))) |=> !cpu_req_ready); // R3

    AST_SINGLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_line_req_valid && mem_line_req_ready && !mem_line_req_we) |=> !mem_line_req_valid); // R3

    AST_EVICT_VALID_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_line_req_valid && mem_line_req_we) |-> (rd_valid && rd_dirty)); // R5

    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_word_wr_valid && !mem_word_wr_ready) |=> (mem_word_wr_valid && $stable(mem_word_wr_addr))); // R7

    generate
        if (!WRITE_BACK) begin : g_wt_chk
            AST_WT_NO_LINE_WR: assert property (@(posedge clk) disable iff (!rst_n)
                mem_line_req_valid |-> !mem_line_req_we); // R7
        end
    endgenerate

endmodule

// File: tb/test_wpcache_ctrl.sv
module test_mem_model #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                          clk,
    input  logic                          line_valid,
    output logic                          line_ready,
    input  logic                          line_we,
    input  logic [ADDR_W-$clog2(WORDS)-1:0] line_addr,
    input  logic [WORDS*DATA_W-1:0]       line_wdata,
    output logic                          rsp_valid,
    output logic [WORDS*DATA_W-1:0]       rsp_data,
    input  logic                          word_valid,
    output logic                          word_ready,
    input  logic [ADDR_W-1:0]             word_addr,
    input  logic [DATA_W-1:0]             word_data
);
    localparam int OFF_W = $clog2(WORDS);
    logic [DATA_W-1:0] mem [2**ADDR_W];
    int n_fill = 0;
    int n_lwr  = 0;
    int n_wwr  = 0;
    int lwr_at_fill = 0;
    int cnt = 0;
    logic [ADDR_W-OFF_W-1:0] pend;

    initial begin
        for (int i = 0; i < 2**ADDR_W; i++) mem[i] = 32'h1000_0000 + i * 32'h0001_0203;
        rsp_valid = 1'b0;
        rsp_data  = '0;
    end

    assign line_ready = 1'b1;
    assign word_ready = 1'b1;

    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        if (cnt == 1) begin
            rsp_valid <= 1'b1;
            for (int w = 0; w < WORDS; w++) rsp_data[w*DATA_W +: DATA_W] <= mem[{pend, w[OFF_W-1:0]}];
        end
        if (cnt > 0) cnt <= cnt - 1;
        if (line_valid && line_ready) begin
            if (line_we) begin
                for (int w = 0; w < WORDS; w++) mem[{line_addr, w[OFF_W-1:0]}] <= line_wdata[w*DATA_W +: DATA_W];
                n_lwr <= n_lwr + 1;
            end else begin
                n_fill      <= n_fill + 1;
                lwr_at_fill <= n_lwr;
                pend        <= line_addr;
                cnt         <= 3;
            end
        end
        if (word_valid && word_ready) begin
            mem[word_addr] <= word_data;
            n_wwr <= n_wwr + 1;
        end
    end
endmodule

module test_wpcache_ctrl;
    localparam int AW = 8, DW = 32, WD = 4, LN = 4;
    localparam int LW = WD * DW;
    localparam int LAW = AW - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid [2];
    logic          req_ready [2];
    logic          req_we    [2];
    logic [AW-1:0] req_addr  [2];
    logic [DW-1:0] req_wdata [2];
    logic          rsp_valid [2];
    logic [DW-1:0] rsp_data  [2];
    logic          ml_valid [2], ml_ready [2], ml_we [2];
    logic [LAW-1:0] ml_addr [2];
    logic [LW-1:0] ml_wdata [2], mr_data [2];
    logic          mr_valid [2];
    logic          mw_valid [2], mw_ready [2];
    logic [AW-1:0] mw_addr [2];
    logic [DW-1:0] mw_data [2];

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp0 [$];
    logic [DW-1:0] exp1 [$];
    logic [DW-1:0] shadow [2][2**AW];

    wpcache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WORDS(WD), .LINES(LN),
                   .WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) i_wpcache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(req_valid[0]), .cpu_req_ready(req_ready[0]), .cpu_req_we(req_we[0]),
        .cpu_req_addr(req_addr[0]), .cpu_req_wdata(req_wdata[0]),
        .cpu_rsp_valid(rsp_valid[0]), .cpu_rsp_data(rsp_data[0]),
        .mem_line_req_valid(ml_valid[0]), .mem_line_req_ready(ml_ready[0]), .mem_line_req_we(ml_we[0]),
        .mem_line_req_addr(ml_addr[0]), .mem_line_req_wdata(ml_wdata[0]),
        .mem_line_rsp_valid(mr_valid[0]), .mem_line_rsp_data(mr_data[0]),
        .mem_word_wr_valid(mw_valid[0]), .mem_word_wr_ready(mw_ready[0]),
        .mem_word_wr_addr(mw_addr[0]), .mem_word_wr_data(mw_data[0])
    );

    wpcache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WORDS(WD), .LINES(LN),
                   .WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) i_wpcache_ctrl_wt (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(req_valid[1]), .cpu_req_ready(req_ready[1]), .cpu_req_we(req_we[1]),
        .cpu_req_addr(req_addr[1]), .cpu_req_wdata(req_wdata[1]),
        .cpu_rsp_valid(rsp_valid[1]), .cpu_rsp_data(rsp_data[1]),
        .mem_line_req_valid(ml_valid[1]), .mem_line_req_ready(ml_ready[1]), .mem_line_req_we(ml_we[1]),
        .mem_line_req_addr(ml_addr[1]), .mem_line_req_wdata(ml_wdata[1]),
        .mem_line_rsp_valid(mr_valid[1]), .mem_line_rsp_data(mr_data[1]),
        .mem_word_wr_valid(mw_valid[1]), .mem_word_wr_ready(mw_ready[1]),
        .mem_word_wr_addr(mw_addr[1]), .mem_word_wr_data(mw_data[1])
    );

    test_mem_model #(.ADDR_W(AW), .DATA_W(DW), .WORDS(WD)) i_mem0 (
        .clk(clk), .line_valid(ml_valid[0]), .line_ready(ml_ready[0]), .line_we(ml_we[0]),
        .line_addr(ml_addr[0]), .line_wdata(ml_wdata[0]), .rsp_valid(mr_valid[0]), .rsp_data(mr_data[0]),
        .word_valid(mw_valid[0]), .word_ready(mw_ready[0]), .word_addr(mw_addr[0]), .word_data(mw_data[0])
    );

    test_mem_model #(.ADDR_W(AW), .DATA_W(DW), .WORDS(WD)) i_mem1 (
        .clk(clk), .line_valid(ml_valid[1]), .line_ready(ml_ready[1]), .line_we(ml_we[1]),
        .line_addr(ml_addr[1]), .line_wdata(ml_wdata[1]), .rsp_valid(mr_valid[1]), .rsp_data(mr_data[1]),
        .word_valid(mw_valid[1]), .word_ready(mw_ready[1]), .word_addr(mw_addr[1]), .word_data(mw_data[1])
    );

    function automatic logic [DW-1:0] init_val(int a);
        return 32'h1000_0000 + a * 32'h0001_0203;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // mode: 0 plain, 1 expect read hit response next cycle, 2 expect stall next cycle
    task automatic req(input int u, input bit we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input int mode);
        @(negedge clk);
        req_valid[u] = 1'b1;
        req_we[u]    = we;
        req_addr[u]  = a;
        req_wdata[u] = d;
        while (!req_ready[u]) @(negedge clk);
        @(posedge clk);
        if (we) shadow[u][a] = d;
        else if (u == 0) exp0.push_back(shadow[u][a]);
        else exp1.push_back(shadow[u][a]);
        @(negedge clk);
        req_valid[u] = 1'b0;
        if (mode == 1) begin
            check(rsp_valid[u] === 1'b1, "R2", "hit response one cycle after acceptance", rsp_valid[u], 1);
            check(req_ready[u] === 1'b1, "R2", "ready stays high on hit", req_ready[u], 1);
        end
        if (mode == 2)
            check(req_ready[u] === 1'b0, "R3", "ready low after miss", req_ready[u], 0);
    endtask

    task automatic wait_idle(input int u);
        while (!req_ready[u]) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid[0]) begin
                if (exp0.size() == 0) check(1'b0, "R2", "unexpected response u0", rsp_data[0], 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp0.pop_front();
                    check(rsp_data[0] === e, "R3", "read data u0", rsp_data[0], e);
                end
            end
            if (rsp_valid[1]) begin
                if (exp1.size() == 0) check(1'b0, "R2", "unexpected response u1", rsp_data[1], 0);
                else begin
                    logic [DW-1:0] e;
                    e = exp1.pop_front();
                    check(rsp_data[1] === e, "R8", "read data u1", rsp_data[1], e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        for (int u = 0; u < 2; u++) begin
            req_valid[u] = 1'b0; req_we[u] = 1'b0; req_addr[u] = '0; req_wdata[u] = '0;
            for (int a = 0; a < 2**AW; a++) shadow[u][a] = init_val(a);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready[0] === 1'b1, "R1", "ready after reset", req_ready[0], 1);
        check(rsp_valid[0] === 1'b0, "R1", "no response after reset", rsp_valid[0], 0);
        check(req_ready[1] === 1'b1, "R1", "ready after reset wt", req_ready[1], 1);

        // ---------- unit 0: write-back, allocate ----------
        req(0, 1'b0, 8'h05, '0, 2);           // R3 miss into invalid line
        wait_idle(0);
        check(i_mem0.n_fill == 1, "R1", "first access misses", i_mem0.n_fill, 1);
        check(i_mem0.n_lwr == 0, "R3", "no write-back from invalid victim", i_mem0.n_lwr, 0);
        req(0, 1'b0, 8'h06, '0, 1);           // R2 hit
        wait_idle(0);
        check(i_mem0.n_fill == 1, "R2", "hit makes no fill", i_mem0.n_fill, 1);
        req(0, 1'b1, 8'h07, 32'hDEAD_0007, 0); // R4 write hit
        wait_idle(0);
        check(i_mem0.mem[8'h07] === init_val(8'h07), "R4", "memory untouched by write hit", i_mem0.mem[8'h07], init_val(8'h07));
        check(i_mem0.n_wwr == 0, "R4", "no word write in write-back", i_mem0.n_wwr, 0);
        req(0, 1'b0, 8'h07, '0, 1);           // R4 read back new value
        wait_idle(0);
        req(0, 1'b0, 8'h45, '0, 2);           // R5 conflict on dirty line
        wait_idle(0);
        check(i_mem0.n_lwr == 1, "R5", "dirty victim written back", i_mem0.n_lwr, 1);
        check(i_mem0.lwr_at_fill == 1, "R5", "write-back before fill", i_mem0.lwr_at_fill, 1);
        check(i_mem0.mem[8'h07] === 32'hDEAD_0007, "R5", "victim data reached memory", i_mem0.mem[8'h07], 32'hDEAD_0007);
        check(i_mem0.mem[8'h06] === init_val(8'h06), "R5", "clean word of victim preserved", i_mem0.mem[8'h06], init_val(8'h06));
        req(0, 1'b1, 8'h88, 32'hBEEF_0088, 0); // R6 write miss with allocate
        wait_idle(0);
        check(i_mem0.n_fill == 3, "R6", "write miss fetches line", i_mem0.n_fill, 3);
        check(i_mem0.n_wwr == 0, "R6", "no word write on allocate", i_mem0.n_wwr, 0);
        check(i_mem0.mem[8'h88] === init_val(8'h88), "R6", "memory not yet updated", i_mem0.mem[8'h88], init_val(8'h88));
        req(0, 1'b0, 8'h89, '0, 1);           // R6 neighbour hits with memory value
        wait_idle(0);
        req(0, 1'b0, 8'h88, '0, 1);           // R6 merged word
        wait_idle(0);
        req(0, 1'b0, 8'hCD, '0, 2);           // R3 clean invalid line idx3
        wait_idle(0);
        check(i_mem0.n_lwr == 1, "R3", "clean miss no write-back", i_mem0.n_lwr, 1);

        // ---------- unit 1: write-through, no-allocate ----------
        req(1, 1'b0, 8'h10, '0, 2);
        wait_idle(1);
        req(1, 1'b1, 8'h11, 32'hCAFE_0011, 0); // R7 write hit
        wait_idle(1);
        check(i_mem1.n_wwr == 1, "R7", "write hit sent to memory", i_mem1.n_wwr, 1);
        check(i_mem1.mem[8'h11] === 32'hCAFE_0011, "R7", "memory holds written word", i_mem1.mem[8'h11], 32'hCAFE_0011);
        req(1, 1'b0, 8'h11, '0, 1);           // R7 cache also updated
        wait_idle(1);
        check(i_mem1.n_fill == 1, "R7", "read after write-through hits", i_mem1.n_fill, 1);
        req(1, 1'b0, 8'h50, '0, 2);           // R7 eviction, no write-back
        wait_idle(1);
        check(i_mem1.n_lwr == 0, "R7", "no line write-back in write-through", i_mem1.n_lwr, 0);
        req(1, 1'b1, 8'h24, 32'hF00D_0024, 0); // R8 write miss no-allocate
        wait_idle(1);
        check(i_mem1.n_fill == 2, "R8", "no fill on no-allocate write miss", i_mem1.n_fill, 2);
        check(i_mem1.mem[8'h24] === 32'hF00D_0024, "R8", "word written to memory", i_mem1.mem[8'h24], 32'hF00D_0024);
        req(1, 1'b0, 8'h24, '0, 2);           // R8 still a miss
        wait_idle(1);
        check(i_mem1.n_fill == 3, "R8", "line was not allocated", i_mem1.n_fill, 3);

        repeat (4) @(negedge clk);
        check(exp0.size() == 0, "R2", "all u0 responses seen", exp0.size(), 0);
        check(exp1.size() == 0, "R3", "all u1 responses seen", exp1.size(), 0);
        summary();
    end
endmodule